// File: doc/BRIEF.md
# Pin sense and latched detect

The block watches a port's input vector and decides, pin by pin, whether each pin is sensing. A pin senses when its input level, after an optional per-pin inversion, is high and sensing is enabled for that pin. The per-pin results are kept in two forms. One is a live vector that follows the pins. The other is a sticky vector that keeps every pin that has sensed since software last cleared it.

Software reads the sticky vector and clears it by writing ones. A clear cannot remove a bit whose pin is still sensing. The block drives a parameterized number of port-level detect outputs, normally two. Each has its own mode bit, which selects whether the output follows the OR of the live vector or the OR of the sticky vector. Each output also has an event line that pulses for one cycle when the output rises, and this line feeds a downstream event unit.

A clear that leaves sticky bits set must still be seen downstream. For that reason, every non-zero clear pulls the latched-mode outputs low for a fixed number of cycles. When the hold ends, the output rises again and produces a new event.

Top module: `pin_sense_detect`

## Requirements
- R1: `live_detect` equals `(pin_in ^ sense_inv) & sense_en` as sampled at the previous clock edge.
- R2: Each `latch_rd` bit becomes 1 in the cycle after its pin senses, and it stays 1 after the pin stops sensing.
- R3: A cycle with `latch_wr` high clears, at the next edge, every `latch_rd` bit written as 1 whose pin is not sensing in that cycle. A bit whose pin is sensing stays set. Bits written as 0 are unaffected.
- R4: When output k is in mode 0 and no hold is active, `detect_out[k]` equals the OR of `live_detect` in the same cycle.
- R5: When output k is in mode 1 and no hold is active, `detect_out[k]` equals the OR of `latch_rd` in the same cycle.
- R6: `detect_evt[k]` is high for exactly the one cycle in which `detect_out[k]` goes from 0 to 1, and it is low in every other cycle.
- R7: A `latch_wr` with non-zero data forces `detect_out[k]` low for CLEAR_HOLD cycles (2 by default) after that edge, for each output k whose mode, including any mode written in the same cycle, is 1. After the hold the output follows R5 again, so remaining sticky bits give a fresh event. A `latch_wr` with all-zero data has no effect.
- R8: `mode_wr` loads `mode_wdata` into `mode_rd` at the next edge. Bit k selects the mode of output k, where 0 means live and 1 means latched. The outputs are independent, and a mode change takes effect in the same cycle as `mode_rd`.
- R9: After reset, all outputs are 0 and both modes are 0.
- R10: With SENSE_EN = 0, `live_detect`, `latch_rd`, `detect_out` and `detect_evt` stay 0 whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Port input levels |
| sense_en | input | NUM_PINS | Per-pin sense enable |
| sense_inv | input | NUM_PINS | Per-pin sense inversion (1 senses low) |
| latch_wr | input | 1 | Write strobe for the sticky vector |
| latch_wdata | input | NUM_PINS | Write-one-to-clear mask |
| mode_wr | input | 1 | Write strobe for the mode bits |
| mode_wdata | input | NUM_OUTS | New mode bits |
| latch_rd | output | NUM_PINS | Sticky detect vector |
| live_detect | output | NUM_PINS | Live per-pin detect vector |
| mode_rd | output | NUM_OUTS | Current mode bits |
| detect_out | output | NUM_OUTS | Port-level detect outputs |
| detect_evt | output | NUM_OUTS | One-cycle rising-edge events |

## Verification
The assertions assume that the write strobes are clean single-cycle pulses. They also assume that a clear and a mode change landing in the same cycle are resolved with the new mode. The random stimulus changes pins and configuration freely, issues clears and mode writes with moderate probability, and lets some clears and mode writes coincide so that this ordering is exercised. Directed phases cover a clear while a pin is still sensing, an all-zero clear, and back-to-back clears during a hold. A second instance with sensing disabled runs on the same stimulus.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic {
    DET_LIVE    = 1'b0,
    DET_LATCHED = 1'b1
  } det_mode_e;
endpackage

// File: rtl/psd_sense_vec.sv
module psd_sense_vec #(
  parameter int NUM_PINS = 8,
  parameter bit SENSE_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] sense_en,
  input  logic [NUM_PINS-1:0] sense_inv,
  input  logic                clr_wr,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] live_o,
  output logic [NUM_PINS-1:0] latch_o,
  output logic                live_any_n,
  output logic                latch_any_n
);
  generate
    if (SENSE_EN) begin : g_on
      logic [NUM_PINS-1:0] live_c, latch_n, live_q, latch_q;

      always_comb begin
        live_c  = (pin_in ^ sense_inv) & sense_en;
        latch_n = (latch_q & ~(clr_wr ? clr_mask : '0)) | live_c;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          live_q  <= '0;
          latch_q <= '0;
        end else begin
          live_q  <= live_c;
          latch_q <= latch_n;
        end
      end

      assign live_o      = live_q;
      assign latch_o     = latch_q;
      assign live_any_n  = |live_c;
      assign latch_any_n = |latch_n;

      assert_latch_covers_live_R2: assert property (@(posedge clk) disable iff (rst)
        (live_q & ~latch_q) == '0);
      assert_clear_takes_effect_R3: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((latch_q & $past(clr_mask) & ~$past(live_c)) == '0));
    end else begin : g_off
      assign live_o      = '0;
      assign latch_o     = '0;
      assign live_any_n  = 1'b0;
      assign latch_any_n = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/psd_detect_port.sv
module psd_detect_port #(
  parameter int CLEAR_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_wr,
  input  logic mode_bit,
  input  logic clr_req,
  input  logic live_any_n,
  input  logic latch_any_n,
  output logic mode_o,
  output logic det_o,
  output logic evt_o
);
  import psd_pkg::*;
  localparam int HW = $clog2(CLEAR_HOLD + 1);

  det_mode_e        mode_q, mode_n;
  logic [HW-1:0]    hold_q, hold_n;
  logic             det_q, det_n, evt_q, sel_n, start;

  always_comb begin
    mode_n = mode_wr ? det_mode_e'(mode_bit) : mode_q;
    start  = clr_req && (mode_n == DET_LATCHED);
    if (start)            hold_n = HW'(CLEAR_HOLD);
    else if (hold_q != 0) hold_n = hold_q - 1'b1;
    else                  hold_n = '0;
    sel_n  = (mode_n == DET_LATCHED) ? latch_any_n : live_any_n;
    det_n  = (hold_n != 0) ? 1'b0 : sel_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= DET_LIVE;
      hold_q <= '0;
      det_q  <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      hold_q <= hold_n;
      det_q  <= det_n;
      evt_q  <= det_n & ~det_q;
    end
  end

  assign mode_o = mode_q;
  assign det_o  = det_q;
  assign evt_o  = evt_q;

  assert_event_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> (det_o && !$past(det_o)));
  assert_rise_gives_event_R6: assert property (@(posedge clk) disable iff (rst)
    (det_o && !$past(det_o)) |-> evt_o);
  assert_clear_forces_low_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_req && (mode_wr ? mode_bit : mode_o)) |=> !det_o);
  assert_mode_load_R8: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (mode_o == $past(mode_bit)));
endmodule

// File: rtl/pin_sense_detect.sv
module pin_sense_detect #(
  parameter int NUM_PINS   = 8,
  parameter int NUM_OUTS   = 2,
  parameter int CLEAR_HOLD = 2,
  parameter bit SENSE_EN   = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] sense_en,
  input  logic [NUM_PINS-1:0] sense_inv,
  input  logic                latch_wr,
  input  logic [NUM_PINS-1:0] latch_wdata,
  input  logic                mode_wr,
  input  logic [NUM_OUTS-1:0] mode_wdata,
  output logic [NUM_PINS-1:0] latch_rd,
  output logic [NUM_PINS-1:0] live_detect,
  output logic [NUM_OUTS-1:0] mode_rd,
  output logic [NUM_OUTS-1:0] detect_out,
  output logic [NUM_OUTS-1:0] detect_evt
);
  logic live_any_n, latch_any_n, clr_req;

  assign clr_req = latch_wr && (latch_wdata != '0);

  psd_sense_vec #(.NUM_PINS(NUM_PINS), .SENSE_EN(SENSE_EN)) u_vec (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sense_en(sense_en),
    .sense_inv(sense_inv), .clr_wr(latch_wr), .clr_mask(latch_wdata),
    .live_o(live_detect), .latch_o(latch_rd),
    .live_any_n(live_any_n), .latch_any_n(latch_any_n)
  );

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_port
    psd_detect_port #(.CLEAR_HOLD(CLEAR_HOLD)) u_port (
      .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_bit(mode_wdata[k]),
      .clr_req(clr_req), .live_any_n(live_any_n), .latch_any_n(latch_any_n),
      .mode_o(mode_rd[k]), .det_o(detect_out[k]), .evt_o(detect_evt[k])
    );
  end

  if (!SENSE_EN) begin : g_chk_off
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      (latch_rd == '0) && (detect_out == '0));
  end
endmodule

// File: tb/pin_sense_detect_test.sv
module pin_sense_detect_test;
  localparam int NP = 8;
  localparam int NO = 2;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] pin_in = '0, sense_en = '0, sense_inv = '0, latch_wdata = '0;
  logic latch_wr = 1'b0, mode_wr = 1'b0;
  logic [NO-1:0] mode_wdata = '0;
  logic [NP-1:0] latch_rd, live_detect, latch_rd_off, live_off;
  logic [NO-1:0] mode_rd, detect_out, detect_evt, mode_off, det_off, evt_off;

  always #5 clk = ~clk;

  pin_sense_detect #(.NUM_PINS(NP), .NUM_OUTS(NO), .CLEAR_HOLD(HOLD)) uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sense_en(sense_en), .sense_inv(sense_inv),
    .latch_wr(latch_wr), .latch_wdata(latch_wdata), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .latch_rd(latch_rd), .live_detect(live_detect), .mode_rd(mode_rd),
    .detect_out(detect_out), .detect_evt(detect_evt));

  pin_sense_detect #(.NUM_PINS(NP), .NUM_OUTS(NO), .CLEAR_HOLD(HOLD), .SENSE_EN(1'b0)) uut_off (
    .clk(clk), .rst(rst), .pin_in(pin_in), .sense_en(sense_en), .sense_inv(sense_inv),
    .latch_wr(latch_wr), .latch_wdata(latch_wdata), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .latch_rd(latch_rd_off), .live_detect(live_off), .mode_rd(mode_off),
    .detect_out(det_off), .detect_evt(evt_off));

  int checks = 0, errors = 0;
  logic [NP-1:0] m_live = '0, m_latch = '0;
  logic [NO-1:0] m_mode = '0, m_det = '0, m_evt = '0;
  int m_hold [NO];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NP-1:0] live_of(input logic [NP-1:0] p, e, v);
    return (p ^ v) & e;
  endfunction

  // Advance the model by one edge using the inputs currently applied.
  task automatic model_edge();
    logic [NP-1:0] lc;
    logic dn;
    lc = live_of(pin_in, sense_en, sense_inv);
    m_latch = (m_latch & ~(latch_wr ? latch_wdata : '0)) | lc;
    m_live = lc;
    if (mode_wr) m_mode = mode_wdata;
    for (int k = 0; k < NO; k++) begin
      if (latch_wr && latch_wdata != 0 && m_mode[k]) m_hold[k] = HOLD;
      else if (m_hold[k] > 0) m_hold[k] = m_hold[k] - 1;
      dn = (m_hold[k] > 0) ? 1'b0 : (m_mode[k] ? |m_latch : |m_live);
      m_evt[k] = dn & ~m_det[k];
      m_det[k] = dn;
    end
  endtask

  task automatic compare(input bit was_clear);
    check("R1 live", 32'(live_detect), 32'(m_live));
    check(was_clear ? "R3 clear" : "R2 sticky", 32'(latch_rd), 32'(m_latch));
    check("R8 mode", 32'(mode_rd), 32'(m_mode));
    for (int k = 0; k < NO; k++) begin
      if (m_hold[k] > 0) check("R7 hold", 32'(detect_out[k]), 32'(m_det[k]));
      else if (m_mode[k]) check("R5 latched", 32'(detect_out[k]), 32'(m_det[k]));
      else check("R4 live mode", 32'(detect_out[k]), 32'(m_det[k]));
    end
    check("R6 event", 32'(detect_evt), 32'(m_evt));
    check("R10 off", 32'({latch_rd_off, live_off, det_off, evt_off}), 32'(0));
  endtask

  // One cycle: apply inputs at the falling edge, update the model at the
  // rising edge, compare shortly after.
  task automatic step(input logic [NP-1:0] p, e, v, input logic wr, input logic [NP-1:0] wd,
                      input logic mw, input logic [NO-1:0] md);
    bit cl;
    @(negedge clk);
    pin_in = p; sense_en = e; sense_inv = v;
    latch_wr = wr; latch_wdata = wd; mode_wr = mw; mode_wdata = md;
    cl = wr;
    @(posedge clk);
    model_edge();
    #1;
    compare(cl);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < NO; k++) m_hold[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 reset", 32'({latch_rd, live_detect, mode_rd, detect_out, detect_evt}), 32'(0));
    @(negedge clk); rst = 1'b0;

    // Directed: pin 2 senses high, pin 5 senses low (inverted), live mode
    step(8'h00, 8'h24, 8'h20, 0, 0, 0, 0);
    step(8'h04, 8'h24, 8'h20, 0, 0, 0, 0);
    step(8'h20, 8'h24, 8'h20, 0, 0, 0, 0);
    // out1 latched, out0 live
    step(8'h20, 8'h24, 8'h20, 0, 0, 1, 2'b10);
    step(8'h00, 8'h24, 8'h20, 0, 0, 0, 0);
    // clear while pin 2 still senses: bit stays, R7 hold and re-raise
    step(8'h04, 8'h24, 8'h20, 0, 0, 0, 0);
    step(8'h04, 8'h24, 8'h20, 1, 8'hFF, 0, 0);
    step(8'h04, 8'h24, 8'h20, 0, 0, 0, 0);
    step(8'h00, 8'h24, 8'h20, 0, 0, 0, 0);
    step(8'h00, 8'h24, 8'h20, 0, 0, 0, 0);
    // zero-data clear has no effect
    step(8'h00, 8'h24, 8'h20, 1, 8'h00, 0, 0);
    step(8'h00, 8'h24, 8'h20, 0, 0, 0, 0);
    // back-to-back clears with same-cycle mode write
    step(8'h20, 8'h24, 8'h20, 1, 8'h01, 1, 2'b11);
    step(8'h20, 8'h24, 8'h20, 1, 8'h04, 0, 0);
    repeat (4) step(8'h20, 8'h24, 8'h20, 0, 0, 0, 0);
    step(8'h20, 8'h24, 8'h20, 1, 8'hFF, 0, 0);
    repeat (4) step(8'h20, 8'h24, 8'h20, 0, 0, 0, 0);

    // Constrained random
    for (int i = 0; i < 600; i++) begin
      logic [NP-1:0] p, e, v, wd;
      logic wr, mw;
      logic [NO-1:0] md;
      p  = NP'($urandom);
      e  = NP'($urandom) & NP'($urandom);
      v  = (i % 50 < 25) ? '0 : NP'($urandom);
      wr = ($urandom % 5) == 0;
      wd = (($urandom % 4) == 0) ? '0 : NP'($urandom);
      mw = ($urandom % 8) == 0;
      md = NO'($urandom);
      if (i % 3 != 0) p = pin_in;
      step(p, e, v, wr, wd, mw, md);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule